// File: doc/BRIEF.md
# Capability Access Check Unit

This block sits between a load, store or instruction-fetch path and memory. It checks every access against an uncompressed 256-bit capability. The capability describes a protected pointer: a validity tag, a region given by base and length, a current offset, permission bits, a seal flag and an object type. The block forms the effective address and checks the access. It then returns either a grant or a 3-bit exception code.

A second operation derives a narrower capability. The new region starts at the effective address and spans the requested size. A request that would widen the region is refused and returns an untagged result.

Data accesses and narrowing use the capability operand. Fetches use a separate program-counter capability and need its execute right. Requests are accepted with a valid/ready handshake. The result is held in one output register with its own valid/ready pair.

Top module: `cap_check_unit`

## Requirements
- R1: After reset, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: If the checked capability has its tag bit clear (bit 255), the result is exception code 1 and no grant.
- R3: A tagged capability whose seal bit (bit 247) is set returns code 2 and no grant.
- R4: The permission field occupies bits 222:192. A load needs permission bit 0 (capability bit 192), a store needs bit 1 and a fetch needs bit 2. A missing bit gives code 3.
- R5: The access must satisfy address >= base and address + size <= base + length. Both sides are computed without 64-bit wraparound. Base is bits 127:64 and length is bits 191:128. A violation gives code 4.
- R6: The effective address is base + offset + displacement, modulo 2^64. Offset is bits 63:0. Offset and displacement are two's complement. The address is returned on `rsp_addr_o` for granted and faulted accesses alike.
- R7: When several faults apply, the reported code follows the priority tag (1), then seal (2), then permission (3), then bounds (4). Code 0 means granted, and `rsp_grant_o` is high exactly then.
- R8: Opcode 3 (narrow) needs no permission bit. On success, `rsp_cap_o` takes base = effective address, length = size and offset = 0, and keeps every other field. A region outside the current one gives code 4. On any fault, `rsp_cap_o` carries the checked capability with its tag cleared.
- R9: A response appears with `rsp_valid_o` high in the cycle after the request is accepted. It stays stable while `rsp_ready_i` is low. During that time `req_ready_o` is low.
- R10: Opcode 2 (fetch) is checked against `pcc_i` alone, and `req_cap_i` has no effect on it. Opcode 0 is load and opcode 1 is store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 2 | 0 load, 1 store, 2 fetch, 3 narrow |
| req_cap_i | input | 256 | Capability operand for load, store and narrow |
| pcc_i | input | 256 | Program-counter capability used for fetch |
| req_disp_i | input | 64 | Signed displacement |
| req_size_i | input | 64 | Access size, or new length for narrow, in bytes |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken |
| rsp_grant_o | output | 1 | Access granted |
| rsp_exc_o | output | 3 | Exception code |
| rsp_addr_o | output | 64 | Effective address |
| rsp_cap_o | output | 256 | Resulting capability |

## Verification
The embedded properties are checked on every cycle:
- a response follows each accepted request;
- a stalled response holds steady;
- a clear tag always wins;
- a tagged sealed capability always reports the seal code;
- a granted narrow never lowers the base or grows the length;
- a refused result is always untagged.

Only the bench scenarios show the rest:
- the exact address arithmetic, including wraparound near the top of the address space;
- the one-byte boundaries at both ends of a region;
- the full four-level priority order;
- fetch ignoring the data operand;
- the field-by-field content of a narrowed capability.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;
  parameter int unsigned ADDR_W  = 64;
  parameter int unsigned PERM_W  = 31;
  parameter int unsigned OTYPE_W = 24;
  parameter int unsigned RSVD_W  = 7;
  parameter int unsigned EXC_W   = 3;
  parameter int unsigned OP_W    = 2;
  localparam int unsigned CAP_W  = 2 + RSVD_W + OTYPE_W + PERM_W + 3 * ADDR_W;

  localparam int unsigned PERM_LOAD  = 0;
  localparam int unsigned PERM_STORE = 1;
  localparam int unsigned PERM_EXEC  = 2;

  typedef struct packed {
    logic               tag;
    logic [RSVD_W-1:0]  rsvd;
    logic               sealed;
    logic [OTYPE_W-1:0] otype;
    logic [PERM_W-1:0]  perms;
    logic [ADDR_W-1:0]  length;
    logic [ADDR_W-1:0]  base;
    logic [ADDR_W-1:0]  offset;
  } cap_t;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_FETCH  = 2'd2,
    OP_BOUNDS = 2'd3
  } op_e;

  typedef enum logic [EXC_W-1:0] {
    EXC_NONE   = 3'd0,
    EXC_TAG    = 3'd1,
    EXC_SEAL   = 3'd2,
    EXC_PERM   = 3'd3,
    EXC_BOUNDS = 3'd4
  } exc_e;
endpackage

// File: rtl/cap_addr_calc.sv
module cap_addr_calc #(
  parameter int unsigned AW = 64
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] disp_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] addr_o,
  output logic          in_bnd_o
);
  // extra headroom bits so no sum or compare wraps
  localparam int unsigned XW  = 4;
  localparam int unsigned EXT = AW + XW;

  logic signed [EXT-1:0] base_x, off_x, disp_x, len_x, size_x;
  logic signed [EXT-1:0] addr_x, end_x, lim_x;

  always_comb begin
    base_x = $signed({{XW{1'b0}}, base_i});
    len_x  = $signed({{XW{1'b0}}, len_i});
    size_x = $signed({{XW{1'b0}}, size_i});
    off_x  = $signed({{XW{off_i[AW-1]}}, off_i});
    disp_x = $signed({{XW{disp_i[AW-1]}}, disp_i});
    addr_x = base_x + off_x + disp_x;
    end_x  = addr_x + size_x;
    lim_x  = base_x + len_x;
  end

  assign addr_o   = addr_x[AW-1:0];
  assign in_bnd_o = (addr_x >= base_x) && (end_x <= lim_x);
endmodule

// File: rtl/cap_perm_check.sv
module cap_perm_check
  import cap_chk_pkg::*;
#(
  parameter int unsigned PW = PERM_W
) (
  input  op_e           op_i,
  input  logic [PW-1:0] perms_i,
  output logic          ok_o
);
  logic [PW-1:0] need;

  always_comb begin
    need = '0;
    case (op_i)
      OP_LOAD:  need[PERM_LOAD]  = 1'b1;
      OP_STORE: need[PERM_STORE] = 1'b1;
      OP_FETCH: need[PERM_EXEC]  = 1'b1;
      default:  need = '0;
    endcase
  end

  assign ok_o = (perms_i & need) == need;
endmodule

// File: rtl/cap_fault_prio.sv
module cap_fault_prio
  import cap_chk_pkg::*;
(
  input  logic tag_i,
  input  logic sealed_i,
  input  logic perm_ok_i,
  input  logic in_bnd_i,
  output exc_e exc_o
);
  always_comb begin
    if (!tag_i)          exc_o = EXC_TAG;
    else if (sealed_i)   exc_o = EXC_SEAL;
    else if (!perm_ok_i) exc_o = EXC_PERM;
    else if (!in_bnd_i)  exc_o = EXC_BOUNDS;
    else                 exc_o = EXC_NONE;
  end
endmodule

// File: rtl/cap_bounds_narrow.sv
module cap_bounds_narrow
  import cap_chk_pkg::*;
(
  input  cap_t              cap_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] len_i,
  output cap_t              cap_o
);
  always_comb begin
    cap_o        = cap_i;
    cap_o.base   = base_i;
    cap_o.length = len_i;
    cap_o.offset = '0;
  end
endmodule

// File: rtl/cap_check_unit.sv
module cap_check_unit
  import cap_chk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [CAP_W-1:0]  req_cap_i,
  input  logic [CAP_W-1:0]  pcc_i,
  input  logic [ADDR_W-1:0] req_disp_i,
  input  logic [ADDR_W-1:0] req_size_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic              rsp_grant_o,
  output logic [EXC_W-1:0]  rsp_exc_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [CAP_W-1:0]  rsp_cap_o
);
  op_e               op;
  cap_t              sel_cap, narrowed, out_cap, cap_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              in_bnd, perm_ok, grant_d, grant_q, valid_q, fire;
  exc_e              exc_d, exc_q;

  assign op      = op_e'(req_op_i);
  assign sel_cap = (op == OP_FETCH) ? cap_t'(pcc_i) : cap_t'(req_cap_i);

  cap_addr_calc #(.AW(ADDR_W)) u_addr (
    .base_i   (sel_cap.base),
    .len_i    (sel_cap.length),
    .off_i    (sel_cap.offset),
    .disp_i   (req_disp_i),
    .size_i   (req_size_i),
    .addr_o   (addr_d),
    .in_bnd_o (in_bnd)
  );

  cap_perm_check #(.PW(PERM_W)) u_perm (
    .op_i    (op),
    .perms_i (sel_cap.perms),
    .ok_o    (perm_ok)
  );

  cap_fault_prio u_prio (
    .tag_i     (sel_cap.tag),
    .sealed_i  (sel_cap.sealed),
    .perm_ok_i (perm_ok),
    .in_bnd_i  (in_bnd),
    .exc_o     (exc_d)
  );

  cap_bounds_narrow u_narrow (
    .cap_i  (sel_cap),
    .base_i (addr_d),
    .len_i  (req_size_i),
    .cap_o  (narrowed)
  );

  assign grant_d = (exc_d == EXC_NONE);

  always_comb begin
    out_cap = sel_cap;
    if (!grant_d)              out_cap.tag = 1'b0;
    else if (op == OP_BOUNDS)  out_cap = narrowed;
  end

  assign req_ready_o = !valid_q || rsp_ready_i;
  assign fire        = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      grant_q <= 1'b0;
      exc_q   <= EXC_NONE;
      addr_q  <= '0;
      cap_q   <= '0;
    end else if (fire) begin
      valid_q <= 1'b1;
      grant_q <= grant_d;
      exc_q   <= exc_d;
      addr_q  <= addr_d;
      cap_q   <= out_cap;
    end else if (rsp_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = valid_q;
  assign rsp_grant_o = grant_q;
  assign rsp_exc_o   = exc_q;
  assign rsp_addr_o  = addr_q;
  assign rsp_cap_o   = cap_q;

  assert_resp_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);

  assert_resp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_addr_o)
      && $stable(rsp_exc_o) && $stable(rsp_grant_o) && $stable(rsp_cap_o));

  assert_tag_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !sel_cap.tag |=> rsp_exc_o == EXC_TAG && !rsp_grant_o);

  assert_seal_fault_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && sel_cap.tag && sel_cap.sealed |=> rsp_exc_o == EXC_SEAL && !rsp_grant_o);

  assert_narrow_monotone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && op == OP_BOUNDS |=> !rsp_grant_o ||
      (cap_q.base >= $past(sel_cap.base) && cap_q.length <= $past(sel_cap.length)));

  assert_fault_untagged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_grant_o |-> !cap_q.tag);
endmodule

// File: tb/cap_check_unit_tb.sv
`timescale 1ns/1ps
module cap_check_unit_tb;
  import cap_chk_pkg::*;

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic        tag;
    logic        sealed;
    logic [2:0]  perms;
    logic [63:0] base;
    logic [63:0] len;
    logic [63:0] off;
    logic [63:0] disp;
    logic [63:0] size;
    logic [2:0]  exc;
    logic [63:0] addr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R5 R6 inside region
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'b001, 64'h1000, 64'h100, 64'h10, 64'h8, 64'h8, 3'd0, 64'h1018},
    // R5 last byte at the top edge
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'b001, 64'h1000, 64'h100, 64'hF8, 64'h0, 64'h8, 3'd0, 64'h10F8},
    // R5 one byte past the top
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'b001, 64'h1000, 64'h100, 64'hF9, 64'h0, 64'h8, 3'd4, 64'h10F9},
    // R5 R6 negative displacement below base
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'b001, 64'h1000, 64'h100, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 3'd4, 64'h0FFF},
    // R4 store without store permission
    '{4'd4, 2'd1, 1'b1, 1'b0, 3'b001, 64'h1000, 64'h100, 64'h10, 64'h0, 64'h4, 3'd3, 64'h1010},
    // R4 store with store permission
    '{4'd4, 2'd1, 1'b1, 1'b0, 3'b010, 64'h1000, 64'h100, 64'h10, 64'h0, 64'h4, 3'd0, 64'h1010},
    // R7 R2 all faults, tag wins
    '{4'd7, 2'd0, 1'b0, 1'b1, 3'b000, 64'h1000, 64'h100, 64'hF9, 64'h0, 64'h8, 3'd1, 64'h10F9},
    // R7 R3 seal over permission and bounds
    '{4'd7, 2'd0, 1'b1, 1'b1, 3'b000, 64'h1000, 64'h100, 64'hF9, 64'h0, 64'h8, 3'd2, 64'h10F9},
    // R7 permission over bounds
    '{4'd7, 2'd0, 1'b1, 1'b0, 3'b000, 64'h1000, 64'h100, 64'hF9, 64'h0, 64'h8, 3'd3, 64'h10F9},
    // R10 fetch uses pcc, data operand untagged
    '{4'd10, 2'd2, 1'b0, 1'b1, 3'b000, 64'h0, 64'h0, 64'h0, 64'h4, 64'h4, 3'd0, 64'h8104},
    // R10 R5 fetch one byte past pcc region
    '{4'd10, 2'd2, 1'b0, 1'b0, 3'b000, 64'h0, 64'h0, 64'h0, 64'hEFD, 64'h4, 3'd4, 64'h8FFD},
    // R5 R6 address wraps past 2^64
    '{4'd5, 2'd0, 1'b1, 1'b0, 3'b001, 64'hFFFF_FFFF_FFFF_FF00, 64'h100, 64'hF0, 64'h20, 64'h8, 3'd4, 64'h10},
    // R8 narrow inside region
    '{4'd8, 2'd3, 1'b1, 1'b0, 3'b000, 64'h1000, 64'h100, 64'h20, 64'h0, 64'h40, 3'd0, 64'h1020},
    // R8 narrow that would widen
    '{4'd8, 2'd3, 1'b1, 1'b0, 3'b000, 64'h1000, 64'h100, 64'h20, 64'h0, 64'hE1, 3'd4, 64'h1020}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [1:0]        req_op_i = '0;
  logic [CAP_W-1:0]  req_cap_i = '0;
  logic [CAP_W-1:0]  pcc_i = '0;
  logic [63:0]       req_disp_i = '0;
  logic [63:0]       req_size_i = '0;
  logic              rsp_valid_o;
  logic              rsp_ready_i = 1'b0;
  logic              rsp_grant_o;
  logic [2:0]        rsp_exc_o;
  logic [63:0]       rsp_addr_o;
  logic [CAP_W-1:0]  rsp_cap_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cap_check_unit u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_cap_i, .pcc_i,
    .req_disp_i, .req_size_i, .rsp_valid_o, .rsp_ready_i, .rsp_grant_o,
    .rsp_exc_o, .rsp_addr_o, .rsp_cap_o
  );

  function automatic cap_t mk_cap(logic t, logic s, logic [2:0] p,
                                  logic [63:0] b, logic [63:0] l, logic [63:0] o);
    cap_t c;
    c = '0;
    c.tag = t; c.sealed = s; c.perms = {28'd0, p};
    c.otype = 24'h5A5; c.rsvd = 7'h11;
    c.base = b; c.length = l; c.offset = o;
    return c;
  endfunction

  task automatic chk(input int r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input cap_t c, input logic [63:0] d, input logic [63:0] s);
    @(negedge clk_i);
    req_op_i = op; req_cap_i = c; req_disp_i = d; req_size_i = s;
    req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cap_t rc;
    pcc_i = mk_cap(1'b1, 1'b0, 3'b100, 64'h8000, 64'h1000, 64'h100);
    #1;
    // R1 reset state
    chk(1, "rsp_valid in reset", {63'd0, rsp_valid_o}, 64'd0);
    chk(1, "req_ready in reset", {63'd0, req_ready_o}, 64'd1);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    chk(1, "rsp_valid after reset", {63'd0, rsp_valid_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].op, mk_cap(VECS[i].tag, VECS[i].sealed, VECS[i].perms,
                              VECS[i].base, VECS[i].len, VECS[i].off),
           VECS[i].disp, VECS[i].size);
      // R9 response visible one cycle after acceptance
      chk(9, "rsp_valid", {63'd0, rsp_valid_o}, 64'd1);
      chk(VECS[i].rq, "exc", {61'd0, rsp_exc_o}, {61'd0, VECS[i].exc});
      chk(VECS[i].rq, "grant", {63'd0, rsp_grant_o}, {63'd0, VECS[i].exc == 3'd0});
      chk(VECS[i].rq, "addr", rsp_addr_o, VECS[i].addr);
      if (VECS[i].op == 2'd3) begin
        rc = cap_t'(rsp_cap_o);
        if (VECS[i].exc == 3'd0) begin
          chk(8, "narrow base", rc.base, VECS[i].addr);
          chk(8, "narrow length", rc.length, VECS[i].size);
          chk(8, "narrow offset", rc.offset, 64'd0);
          chk(8, "narrow tag", {63'd0, rc.tag}, 64'd1);
          chk(8, "narrow otype", {40'd0, rc.otype}, 64'h5A5);
        end else begin
          chk(8, "refused tag", {63'd0, rc.tag}, 64'd0);
        end
      end
    end

    // R4 fetch through a pcc lacking the execute bit
    pcc_i = mk_cap(1'b1, 1'b0, 3'b011, 64'h8000, 64'h1000, 64'h100);
    send(2'd2, mk_cap(1'b1, 1'b0, 3'b111, 64'h0, 64'hFFFF, 64'h0), 64'h0, 64'h4);
    chk(4, "fetch no exec exc", {61'd0, rsp_exc_o}, 64'd3);
    pcc_i = mk_cap(1'b1, 1'b0, 3'b100, 64'h8000, 64'h1000, 64'h100);

    // R9 backpressure: response held, request refused
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    send(2'd0, mk_cap(1'b1, 1'b0, 3'b001, 64'h1000, 64'h100, 64'h10), 64'h8, 64'h8);
    chk(9, "held valid", {63'd0, rsp_valid_o}, 64'd1);
    chk(9, "ready low while held", {63'd0, req_ready_o}, 64'd0);
    req_op_i = 2'd0; req_disp_i = 64'h40; req_valid_i = 1'b1;
    repeat (2) @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(9, "held addr", rsp_addr_o, 64'h1018);
    chk(9, "held exc", {61'd0, rsp_exc_o}, 64'd0);
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    chk(9, "released valid", {63'd0, rsp_valid_o}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule